// File: doc/BRIEF.md
# Six-Channel Packed Serial Audio Receiver

This block takes six audio channels that share one serial data line and turns them back into six parallel 24-bit words. A bit clock and a left/right framing clock come with the data. Two packed framings are supported. The short framing has 128 bit clocks per sample interval: three 20-clock left slots, a 4-clock gap, three 20-clock right slots and a 4-clock gap. The long framing has 256 bit clocks per sample interval, split into eight 32-clock slots. In the long framing each word starts one bit clock into its slot, and the fourth and eighth slots are blank.

The receiver runs directly on the bit clock and samples the data line on its rising edge. The transmitter changes the line on the falling edge. The framing clock edge that starts the left group marks the frame start and restarts the bit position counter. Each received word is stored left-aligned, with the unused low bits cleared. All six words and a one-cycle frame-valid strobe are published together once the last right slot has ended.

Top module: `hexrx_top`

## Requirements
- R1: While reset is low, and after it until a complete frame has arrived, `samples_o` is all zeros and `frame_valid_o` is low.
- R2: A frame starts at the rising bit-clock edge where `lrck_i` first shows the left-group level after holding the other level. The left-group level is high when `mode256_i`=0 and low when `mode256_i`=1. That edge is bit position 0 of the frame.
- R3: With `mode256_i`=0, left channels 0, 1 and 2 start at positions 0, 20 and 40. Right channels 0, 1 and 2 start at positions 64, 84 and 104. Positions 60–63 and 124–127 carry no data.
- R4: With `mode256_i`=1, the MSB of each word is one position after its slot start. Left channels 0, 1 and 2 have MSBs at positions 1, 33 and 65, right channels 0, 1 and 2 at 129, 161 and 193. Slots 96–127 and 224–255 carry no data.
- R5: `wlen_i` selects the word length: 0 gives 16 bits, 1 gives 20 bits, 2 or 3 gives 24 bits. With `mode256_i`=0, a 24-bit selection is treated as 20 bits.
- R6: Each word is sent MSB first. It lands left-aligned in its 24-bit lane, with the lane bits below the word length equal to zero. Bits on the line after the word inside a slot are ignored.
- R7: `frame_valid_o` pulses high for exactly one cycle, on the edge at position 124 (`mode256_i`=0) or 224 (`mode256_i`=1). All six lanes of `samples_o` change on that same edge and hold at all other times.
- R8: Lane k of `samples_o` is bits [24k+23:24k]. Lanes 0–2 are left channels 0–2 and lanes 3–5 are right channels 0–2.
- R9: A frame cut short by a new frame start before its end position produces no strobe and leaves `samples_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Bit clock; data sampled on its rising edge |
| rst_n_i | input | 1 | Synchronous active-low reset |
| lrck_i | input | 1 | Left/right framing clock |
| sdata_i | input | 1 | Serial data carrying six channels |
| mode256_i | input | 1 | 0: 128-clock framing, 1: 256-clock framing |
| wlen_i | input | 2 | Word length select (0:16, 1:20, 2/3:24) |
| samples_o | output | 144 | Six left-aligned 24-bit words, lane k at [24k+23:24k] |
| frame_valid_o | output | 1 | One-cycle strobe when a full frame is published |

## Verification
The assertions assume that `mode256_i` and `wlen_i` only change between frames, and that `lrck_i` only toggles at the group boundaries of the selected framing. The stimulus changes mode and word length only during idle gaps. In those gaps the framing clock sits at the right-group level of the new mode, so a mode change never creates a false frame start. Random words are mixed with random filler bits in the gaps, delay bits and slot tails, so ignored bits differ from frame to frame. Deliberately cut-short frames exercise the restart path.

// File: rtl/hexrx_pkg.sv
// Package: shared widths and framing constants for the six-channel packed receiver.
// Assumes: bit positions within a sample interval fit in eight bits.
package hexrx_pkg;
    localparam int WORD_W = 24;
    localparam int NCH    = 6;
    localparam int POS_W  = 8;
    localparam int BIDX_W = 5;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [BIDX_W-1:0] bidx_t;

    // short framing: 20-clock slots, 64-clock groups, strobe at 124
    localparam pos_t SLOT_S  = 8'd20;
    localparam pos_t GAP_S   = 8'd60;
    localparam pos_t FRAME_S = 8'd128;
    localparam pos_t END_S   = 8'd124;
    // long framing: 32-clock slots, strobe at 224
    localparam pos_t END_L   = 8'd224;
    localparam pos_t POS_MAX = 8'hFF;
endpackage

// File: rtl/hexrx_slot_map.sv
// Module: hexrx_slot_map
// Maps a frame bit position to the channel lane being received and the bit
// index within its word. Purely combinational.
// Assumes: pos is the position since the last frame start; wbits <= 24.
module hexrx_slot_map
    import hexrx_pkg::*;
(
    input  pos_t               pos,
    input  logic               mode256,
    input  bidx_t              wbits,
    output logic [NCH-1:0]     hit,
    output bidx_t              bidx
);
    logic        right;
    logic [1:0]  slot;
    logic        in_slot;
    pos_t        off;

    // Purpose: decode group, slot and in-word offset for the active framing.
    always_comb begin
        right   = 1'b0;
        slot    = 2'd0;
        in_slot = 1'b0;
        off     = '0;
        if (mode256) begin
            right = pos[7];
            slot  = pos[6:5];
            if (slot != 2'd3 && pos[4:0] != 5'd0) begin
                in_slot = 1'b1;
                off     = {3'b000, pos[4:0]} - 8'd1;
            end
        end else if (pos < FRAME_S) begin
            right = pos[6];
            off   = {2'b00, pos[5:0]};
            if (off < SLOT_S) begin
                slot = 2'd0; in_slot = 1'b1;
            end else if (off < SLOT_S + SLOT_S) begin
                slot = 2'd1; in_slot = 1'b1; off = off - SLOT_S;
            end else if (off < GAP_S) begin
                slot = 2'd2; in_slot = 1'b1; off = off - SLOT_S - SLOT_S;
            end
        end
        bidx = off[BIDX_W-1:0];
    end

    // Purpose: raise the lane strobe only for bits inside the word length.
    always_comb begin
        hit = '0;
        if (in_slot && (bidx < wbits)) begin
            hit[{1'b0, slot} + (right ? 3'd3 : 3'd0)] = 1'b1;
        end
    end
endmodule

// File: rtl/hexrx_lane.sv
// Module: hexrx_lane
// Collects one channel's word, MSB first, left-aligned in WORD_W bits.
// The first bit of a word clears the rest of the register, giving zero fill.
// Assumes: bit index 0 arrives before any other bit of the same word.
module hexrx_lane #(
    parameter int WORD_W = 24,
    parameter int BIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [BIDX_W-1:0] bidx,
    input  logic              sdata,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] bit_at_top;
    assign bit_at_top = {sdata, {(WORD_W-1){1'b0}}};

    // Purpose: write the incoming bit at its left-aligned position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (hit) begin
            if (bidx == '0) word <= bit_at_top;
            else            word <= word | (bit_at_top >> bidx);
        end
    end
endmodule

// File: rtl/hexrx_top.sv
// Module: hexrx_top
// Six-channel packed serial receiver on the bit clock. It detects the frame
// start from the framing clock, counts bit positions, steers bits into six
// lanes and publishes all lanes with a one-cycle strobe at the frame end.
// Assumes: mode and word length stay constant within a frame.
module hexrx_top
    import hexrx_pkg::*;
(
    input  logic                  bclk_i,
    input  logic                  rst_n_i,
    input  logic                  lrck_i,
    input  logic                  sdata_i,
    input  logic                  mode256_i,
    input  logic [1:0]            wlen_i,
    output logic [NCH*WORD_W-1:0] samples_o,
    output logic                  frame_valid_o
);
    logic              lrck_q;
    logic              start;
    pos_t              cnt;
    pos_t              pos_now;
    bidx_t             wbits;
    bidx_t             bidx;
    logic [NCH-1:0]    hit;
    logic [WORD_W-1:0] cap_w [NCH];
    logic              fire;

    // Purpose: remember the previous framing-clock level.
    always_ff @(posedge bclk_i) begin
        if (!rst_n_i) lrck_q <= mode256_i;
        else          lrck_q <= lrck_i;
    end

    // Purpose: a frame starts on the edge into the left-group level.
    assign start = (lrck_i != lrck_q) && (lrck_i == !mode256_i);

    // Purpose: position of the current bit; saturates when no frame is running.
    assign pos_now = start ? '0 : ((cnt == POS_MAX) ? POS_MAX : cnt + 8'd1);

    // Purpose: keep the bit position counter; idle (saturated) after reset.
    always_ff @(posedge bclk_i) begin
        if (!rst_n_i) cnt <= POS_MAX;
        else          cnt <= pos_now;
    end

    // Purpose: effective word length; the short framing caps it at 20.
    always_comb begin
        case (wlen_i)
            2'd0:    wbits = 5'd16;
            2'd1:    wbits = 5'd20;
            default: wbits = mode256_i ? 5'd24 : 5'd20;
        endcase
    end

    hexrx_slot_map u_map (
        .pos     (pos_now),
        .mode256 (mode256_i),
        .wbits   (wbits),
        .hit     (hit),
        .bidx    (bidx)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        hexrx_lane #(.WORD_W(WORD_W), .BIDX_W(BIDX_W)) u_lane (
            .clk   (bclk_i),
            .rst_n (rst_n_i),
            .hit   (hit[g]),
            .bidx  (bidx),
            .sdata (sdata_i),
            .word  (cap_w[g])
        );
    end

    assign fire = (pos_now == (mode256_i ? END_L : END_S));

    // Purpose: publish all lanes and pulse the strobe at the frame end.
    always_ff @(posedge bclk_i) begin
        if (!rst_n_i) begin
            samples_o     <= '0;
            frame_valid_o <= 1'b0;
        end else begin
            frame_valid_o <= fire;
            if (fire) begin
                for (int k = 0; k < NCH; k++) begin
                    samples_o[k*WORD_W +: WORD_W] <= cap_w[k];
                end
            end
        end
    end
endmodule

// File: rtl/hexrx_checks.sv
// Module: hexrx_checks
// Assertion checker bound into hexrx_top. It observes the ports and the
// signals passed between the position counter, the slot map and the lanes.
// Assumes: mode and word length change only between frames.
module hexrx_checks
    import hexrx_pkg::*;
(
    input  logic                  bclk_i,
    input  logic                  rst_n_i,
    input  logic                  mode256_i,
    input  logic                  frame_valid_o,
    input  logic [NCH*WORD_W-1:0] samples_o,
    input  logic                  start,
    input  pos_t                  pos_now,
    input  logic [NCH-1:0]        hit,
    input  bidx_t                 bidx,
    input  bidx_t                 wbits
);
    p_strobe_single_r7: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        frame_valid_o |=> !frame_valid_o);

    p_hold_between_r7: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        !frame_valid_o |-> $stable(samples_o));

    p_one_lane_r8: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        $onehot0(hit));

    p_bit_in_word_r5: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        (|hit) |-> (bidx < wbits));

    p_short_cap_r5: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        !mode256_i |-> (wbits <= 5'd20));

    p_restart_no_strobe_r9: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        start |=> !frame_valid_o);

    p_gap_silent_r3: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        (!mode256_i && pos_now >= 8'd60 && pos_now < 8'd64) |-> (hit == '0));

    p_delay_bit_r4: assert property (@(posedge bclk_i) disable iff (!rst_n_i)
        (mode256_i && pos_now[4:0] == 5'd0) |-> (hit == '0));
endmodule

bind hexrx_top hexrx_checks u_checks (
    .bclk_i        (bclk_i),
    .rst_n_i       (rst_n_i),
    .mode256_i     (mode256_i),
    .frame_valid_o (frame_valid_o),
    .samples_o     (samples_o),
    .start         (start),
    .pos_now       (pos_now),
    .hit           (hit),
    .bidx          (bidx),
    .wbits         (wbits)
);

// File: tb/hexrx_top_test.sv
// Bench for hexrx_top: directed and seeded random frames in both framings,
// with expected words computed from the requirements.
module hexrx_top_test;
    logic         bclk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lrck = 1'b0;
    logic         sdata = 1'b0;
    logic         mode256 = 1'b0;
    logic [1:0]   wlen = 2'd0;
    logic [143:0] samples;
    logic         fvalid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [23:0] cur [6];
    logic [23:0] expw [6];

    always #10 bclk = ~bclk;

    hexrx_top uut (
        .bclk_i(bclk), .rst_n_i(rst_n), .lrck_i(lrck), .sdata_i(sdata),
        .mode256_i(mode256), .wlen_i(wlen),
        .samples_o(samples), .frame_valid_o(fvalid)
    );

    function automatic int eff_w(input bit m, input logic [1:0] wl);
        if (wl == 2'd0) return 16;
        if (wl == 2'd1) return 20;
        return m ? 24 : 20;
    endfunction

    function automatic logic [23:0] aligned(input logic [23:0] s, input int w);
        logic [23:0] mask;
        mask = 24'hFFFFFF << (24 - w);
        return s & mask;
    endfunction

    // first data position of channel ch (R3, R4)
    function automatic int first_pos(input bit m, input int ch);
        int grp = (ch >= 3) ? 1 : 0;
        int sl  = ch % 3;
        if (m) return grp * 128 + sl * 32 + 1;
        return grp * 64 + sl * 20;
    endfunction

    function automatic logic line_bit(input bit m, input int w, input int p);
        for (int ch = 0; ch < 6; ch++) begin
            int f = first_pos(m, ch);
            if (p >= f && p < f + w) return cur[ch][23 - (p - f)];
        end
        return 1'($urandom);   // filler, must be ignored (R6)
    endfunction

    function automatic logic lr_level(input bit m, input int p);
        if (m) return (p < 128) ? 1'b0 : 1'b1;
        return (p < 64) ? 1'b1 : 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [143:0] act,
                         input logic [143:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [143:0] exp_bus();
        logic [143:0] b;
        for (int k = 0; k < 6; k++) b[k*24 +: 24] = expw[k];
        return b;
    endfunction

    // idle at the right-group level of the current mode (no frame start)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge bclk);
            lrck  = mode256 ? 1'b1 : 1'b0;
            sdata = 1'($urandom);
        end
    endtask

    // send positions 0..npos-1 of a frame; full frames are checked at the end
    task automatic send(input int npos);
        int w    = eff_w(mode256, wlen);
        int endp = mode256 ? 224 : 124;
        int flen = mode256 ? 256 : 128;
        bit spurious = 1'b0;
        bit seen = 1'b0;
        for (int p = 0; p < npos; p++) begin
            @(negedge bclk);
            lrck  = lr_level(mode256, p);
            sdata = line_bit(mode256, w, p);
            @(posedge bclk);
            #1;
            if (fvalid) begin
                if (p == endp && npos == flen) seen = 1'b1;
                else spurious = 1'b1;
            end
            if (p == endp && npos == flen) begin
                for (int k = 0; k < 6; k++) expw[k] = aligned(cur[k], w);
                // R3/R4/R5/R6/R8: all lanes left-aligned, zero-filled, in order
                check(samples == exp_bus(), mode256 ? "R4 R5 R6 R8 long" : "R3 R5 R6 R8 short",
                      samples, exp_bus());
            end
        end
        if (npos == flen) begin
            check(seen && !spurious, "R7 strobe once at end", {142'd0, spurious, seen}, 144'd1);
        end else begin
            check(!spurious, "R9 cut frame no strobe", {143'd0, spurious}, 144'd0);
            check(samples == exp_bus(), "R9 cut frame holds", samples, exp_bus());
        end
    endtask

    task automatic frame(input bit m, input logic [1:0] wl);
        mode256 = m;
        wlen = wl;
        idle(3);
        send(m ? 256 : 128);
    endtask

    task automatic rand_words();
        for (int k = 0; k < 6; k++) cur[k] = 24'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        for (int k = 0; k < 6; k++) expw[k] = '0;
        repeat (4) @(posedge bclk);
        #1;
        // R1: reset state
        check(samples == '0 && !fvalid, "R1 reset", {samples[142:0], fvalid}, 144'd0);
        @(negedge bclk);
        rst_n = 1'b1;
        idle(20);
        #1;
        check(samples == '0 && !fvalid, "R1 idle after reset", {samples[142:0], fvalid}, 144'd0);

        // directed: distinct word per lane, every mode and length (R2-R8)
        for (int m = 0; m < 2; m++) begin
            for (int wl = 0; wl < 4; wl++) begin
                for (int k = 0; k < 6; k++) cur[k] = 24'h111111 * (k + 1) ^ 24'hA5C3E1;
                frame(m[0], wl[1:0]);
            end
        end
        // corner: all ones then all zeros with random filler (R6)
        for (int k = 0; k < 6; k++) cur[k] = 24'hFFFFFF;
        frame(1'b0, 2'd0);
        frame(1'b1, 2'd1);
        for (int k = 0; k < 6; k++) cur[k] = 24'h000000;
        frame(1'b1, 2'd2);

        // R9: cut-short frames in both framings, then a normal frame
        rand_words();
        mode256 = 1'b0; idle(3); send(100);
        rand_words(); frame(1'b0, 2'd1);
        rand_words();
        mode256 = 1'b1; idle(3); send(200);
        rand_words(); frame(1'b1, 2'd2);

        // seeded random frames (R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 40; i++) begin
            rand_words();
            frame(1'($urandom), 2'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge bclk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule